// File: doc/BRIEF.md
# Baudot Keyboard Shift Codec

This block sits between a character source and a five-level teleprinter line. On the send side it accepts 7-bit ASCII key codes and produces 5-bit Baudot codes. The 5-bit alphabet has two cases, letters and figures, and the same code means different characters in each. The block keeps track of which case the line is in. When a key needs the other case, it first sends the matching case-change code, flips its tracked case, and parks the real code in a one-entry pending slot. The parked code goes out in the very next output slot. Keys that have no translation are taken and discarded.

On the receive side the block accepts 5-bit codes coming back from the line and turns them into ASCII. The two case-change codes only update the tracked case and print nothing. Every other code is looked up together with the tracked case. One case register serves both directions. If both sides try to change it in the same cycle, the receive side wins.

The translation table holds a small representative subset: letters A, E, O, T, figures 3, 5, 9 and '-', and space, carriage return and line feed. All three streams use valid/ready handshakes, and both result streams come from registers.

Top module: `baudot_shift_codec`

## Requirements
- R1: While reset is held and after it is released, `bd_valid` and `pr_valid` are 0, `shift_state` is 0 (letters case) and `asc_ready` is 1.
- R2: The letters case-change code is 5'b11111 (octal 37). The figures case-change code is 5'b11011 (octal 33).
- R3: Encoding subset. Letters case: A=24, E=16, O=3, T=1. Figures case: 3=16, 9=3, 5=1, '-'=24. Either case: space=4, CR=2, LF=8. Any other ASCII value is untranslatable.
- R4: A key marked either-case, or a key whose case equals `shift_state`, produces exactly one output code. That code is its table code, and `shift_state` does not change.
- R5: Any other translatable key produces the case-change code for its own case, followed by its table code. `shift_state` changes to the key's case (1 = figures).
- R6: An untranslatable key is accepted and produces no output code. `shift_state` does not change.
- R7: While a table code is pending behind a case-change code, `asc_ready` is 0.
- R8: Lowercase letters a to z translate exactly like their uppercase forms.
- R9: A received figures code sets `shift_state` to 1 and a received letters code sets it to 0. Neither raises `pr_valid`.
- R10: Any other received code is decoded with the current case, using the R3 table in reverse. Codes with no entry decode to 0.
- R11: If the encoder and the decoder both change the case in the same cycle, `shift_state` takes the decoder's value.
- R12: While a result is valid and its ready is low, the valid stays high and the data stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| asc_valid | input | 1 | Key code offered |
| asc_data | input | 7 | ASCII key code |
| asc_ready | output | 1 | Key code taken this cycle when valid |
| bd_valid | output | 1 | Line code available |
| bd_data | output | 5 | Baudot code toward the line |
| bd_ready | input | 1 | Line side takes the code |
| rx_valid | input | 1 | Received code offered |
| rx_data | input | 5 | Baudot code from the line |
| rx_ready | output | 1 | Received code taken this cycle when valid |
| pr_valid | output | 1 | Decoded character available |
| pr_data | output | 7 | Decoded ASCII character |
| pr_ready | input | 1 | Printer side takes the character |
| shift_state | output | 1 | Tracked case, 0 letters, 1 figures |

## Verification
The bench builds the block with its default widths: 7-bit ASCII and 5-bit codes. This covers every translation entry, both case-change codes and every code that aliases between the two cases. Random keys with random backpressure on the line side reach case flips that arrive while the output register is stalled, as well as back-to-back keys that need a switch. Directed steps cover the receive side and the same-cycle case conflict.

// File: rtl/baudot_pkg.sv
package baudot_pkg;
  localparam int ASC_W  = 7;
  localparam int CODE_W = 5;
  localparam logic [CODE_W-1:0] LTRS_CODE = 5'b11111;
  localparam logic [CODE_W-1:0] FIGS_CODE = 5'b11011;

  // all-zero entry marks an untranslatable key
  typedef struct packed {
    logic              both;
    logic              fig;
    logic [CODE_W-1:0] code;
  } enc_entry_t;

  function automatic enc_entry_t enc_lookup(input logic [ASC_W-1:0] a);
    logic [ASC_W-1:0] u;
    enc_entry_t e;
    u = (a >= 7'h61 && a <= 7'h7a) ? a - 7'h20 : a;
    e = '0;
    case (u)
      7'h41: e = '{both: 1'b0, fig: 1'b0, code: 5'd24}; // A
      7'h45: e = '{both: 1'b0, fig: 1'b0, code: 5'd16}; // E
      7'h4f: e = '{both: 1'b0, fig: 1'b0, code: 5'd3};  // O
      7'h54: e = '{both: 1'b0, fig: 1'b0, code: 5'd1};  // T
      7'h33: e = '{both: 1'b0, fig: 1'b1, code: 5'd16}; // 3
      7'h39: e = '{both: 1'b0, fig: 1'b1, code: 5'd3};  // 9
      7'h35: e = '{both: 1'b0, fig: 1'b1, code: 5'd1};  // 5
      7'h2d: e = '{both: 1'b0, fig: 1'b1, code: 5'd24}; // -
      7'h20: e = '{both: 1'b1, fig: 1'b0, code: 5'd4};  // space
      7'h0d: e = '{both: 1'b1, fig: 1'b0, code: 5'd2};  // CR
      7'h0a: e = '{both: 1'b1, fig: 1'b0, code: 5'd8};  // LF
      default: e = '0;
    endcase
    return e;
  endfunction

  function automatic logic [ASC_W-1:0] dec_lookup(input logic sh,
                                                  input logic [CODE_W-1:0] c);
    logic [ASC_W-1:0] r;
    r = '0;
    case ({sh, c})
      6'd24: r = 7'h41;
      6'd16: r = 7'h45;
      6'd3:  r = 7'h4f;
      6'd1:  r = 7'h54;
      6'd56: r = 7'h2d;
      6'd48: r = 7'h33;
      6'd35: r = 7'h39;
      6'd33: r = 7'h35;
      6'd4, 6'd36: r = 7'h20;
      6'd2, 6'd34: r = 7'h0d;
      6'd8, 6'd40: r = 7'h0a;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/baudot_case_reg.sv
module baudot_case_reg (
  input  logic clk,
  input  logic rst,
  input  logic dec_set,
  input  logic dec_val,
  input  logic enc_set,
  input  logic enc_val,
  output logic shift_q
);
  always_ff @(posedge clk) begin
    if (rst)          shift_q <= 1'b0;
    else if (dec_set) shift_q <= dec_val;
    else if (enc_set) shift_q <= enc_val;
  end

  // R11: receive side wins a same-cycle update
  a_r11_dec_wins: assert property (@(posedge clk) disable iff (rst)
    (dec_set && !rst) |=> (shift_q == $past(dec_val)));
  // R5: an encoder-only change lands
  a_r5_enc_lands: assert property (@(posedge clk) disable iff (rst)
    (enc_set && !dec_set && !rst) |=> (shift_q == $past(enc_val)));
endmodule

// File: rtl/baudot_encoder.sv
module baudot_encoder
  import baudot_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              asc_valid,
  input  logic [ASC_W-1:0]  asc_data,
  output logic              asc_ready,
  output logic              bd_valid,
  output logic [CODE_W-1:0] bd_data,
  input  logic              bd_ready,
  input  logic              shift_q,
  output logic              enc_set,
  output logic              enc_val
);
  logic              out_v, pend_v;
  logic [CODE_W-1:0] out_d, pend_d;
  enc_entry_t        ent;
  logic              slot_free, take, known, direct;

  assign ent       = enc_lookup(asc_data);
  assign slot_free = !out_v || bd_ready;
  assign asc_ready = !pend_v && slot_free;
  assign take      = asc_valid && asc_ready;
  assign known     = (ent != '0);
  assign direct    = ent.both || (ent.fig == shift_q);
  assign enc_set   = take && known && !direct;
  assign enc_val   = ent.fig;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v  <= 1'b0;
      out_d  <= '0;
      pend_v <= 1'b0;
      pend_d <= '0;
    end else if (pend_v && slot_free) begin
      out_v  <= 1'b1;
      out_d  <= pend_d;
      pend_v <= 1'b0;
    end else if (take && known) begin
      out_v <= 1'b1;
      if (direct) begin
        out_d <= ent.code;
      end else begin
        out_d  <= ent.fig ? FIGS_CODE : LTRS_CODE;
        pend_v <= 1'b1;
        pend_d <= ent.code;
      end
    end else if (bd_ready) begin
      out_v <= 1'b0;
    end
  end

  assign bd_valid = out_v;
  assign bd_data  = out_d;

  a_r7_pend_blocks_keys: assert property (@(posedge clk) disable iff (rst)
    pend_v |-> !asc_ready);
  a_r5_case_code_leads: assert property (@(posedge clk) disable iff (rst)
    pend_v |-> (bd_valid && (bd_data == FIGS_CODE || bd_data == LTRS_CODE)));
  a_r12_bd_hold: assert property (@(posedge clk) disable iff (rst)
    (bd_valid && !bd_ready) |=> (bd_valid && $stable(bd_data)));
endmodule

// File: rtl/baudot_decoder.sv
module baudot_decoder
  import baudot_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [CODE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              pr_valid,
  output logic [ASC_W-1:0]  pr_data,
  input  logic              pr_ready,
  input  logic              shift_q,
  output logic              dec_set,
  output logic              dec_val
);
  logic             pr_v;
  logic [ASC_W-1:0] pr_d;
  logic             take, is_fig, is_ltr;

  assign rx_ready = !pr_v || pr_ready;
  assign take     = rx_valid && rx_ready;
  assign is_fig   = (rx_data == FIGS_CODE);
  assign is_ltr   = (rx_data == LTRS_CODE);
  assign dec_set  = take && (is_fig || is_ltr);
  assign dec_val  = is_fig;

  always_ff @(posedge clk) begin
    if (rst) begin
      pr_v <= 1'b0;
      pr_d <= '0;
    end else if (take && !is_fig && !is_ltr) begin
      pr_v <= 1'b1;
      pr_d <= dec_lookup(shift_q, rx_data);
    end else if (pr_ready) begin
      pr_v <= 1'b0;
    end
  end

  assign pr_valid = pr_v;
  assign pr_data  = pr_d;

  a_r9_case_code_silent: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ready && (rx_data == FIGS_CODE || rx_data == LTRS_CODE))
      |=> !pr_valid);
  a_r12_pr_hold: assert property (@(posedge clk) disable iff (rst)
    (pr_valid && !pr_ready) |=> (pr_valid && $stable(pr_data)));
endmodule

// File: rtl/baudot_shift_codec.sv
module baudot_shift_codec
  import baudot_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              asc_valid,
  input  logic [ASC_W-1:0]  asc_data,
  output logic              asc_ready,
  output logic              bd_valid,
  output logic [CODE_W-1:0] bd_data,
  input  logic              bd_ready,
  input  logic              rx_valid,
  input  logic [CODE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              pr_valid,
  output logic [ASC_W-1:0]  pr_data,
  input  logic              pr_ready,
  output logic              shift_state
);
  logic shift_q, enc_set, enc_val, dec_set, dec_val;

  baudot_case_reg u_case (
    .clk(clk), .rst(rst), .dec_set(dec_set), .dec_val(dec_val),
    .enc_set(enc_set), .enc_val(enc_val), .shift_q(shift_q));

  baudot_encoder u_enc (
    .clk(clk), .rst(rst), .asc_valid(asc_valid), .asc_data(asc_data),
    .asc_ready(asc_ready), .bd_valid(bd_valid), .bd_data(bd_data),
    .bd_ready(bd_ready), .shift_q(shift_q), .enc_set(enc_set),
    .enc_val(enc_val));

  baudot_decoder u_dec (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .pr_valid(pr_valid), .pr_data(pr_data),
    .pr_ready(pr_ready), .shift_q(shift_q), .dec_set(dec_set),
    .dec_val(dec_val));

  assign shift_state = shift_q;

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!bd_valid && !pr_valid && !shift_state));
endmodule

// File: tb/baudot_shift_codec_tb.sv
module baudot_shift_codec_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       asc_valid = 1'b0;
  logic [6:0] asc_data = '0;
  logic       asc_ready;
  logic       bd_valid;
  logic [4:0] bd_data;
  logic       bd_ready = 1'b1;
  logic       rx_valid = 1'b0;
  logic [4:0] rx_data = '0;
  logic       rx_ready;
  logic       pr_valid;
  logic [6:0] pr_data;
  logic       pr_ready = 1'b1;
  logic       shift_state;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  baudot_shift_codec u_dut (
    .clk(clk), .rst(rst), .asc_valid(asc_valid), .asc_data(asc_data),
    .asc_ready(asc_ready), .bd_valid(bd_valid), .bd_data(bd_data),
    .bd_ready(bd_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .pr_valid(pr_valid), .pr_data(pr_data),
    .pr_ready(pr_ready), .shift_state(shift_state));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected table from R3, R8; returns {known, fig, both, code}
  function automatic logic [7:0] model_entry(input logic [6:0] c);
    logic [6:0] u;
    u = (c >= "a" && c <= "z") ? c - 7'd32 : c;
    case (u)
      "A": return {1'b1, 1'b0, 1'b0, 5'd24};
      "E": return {1'b1, 1'b0, 1'b0, 5'd16};
      "O": return {1'b1, 1'b0, 1'b0, 5'd3};
      "T": return {1'b1, 1'b0, 1'b0, 5'd1};
      "3": return {1'b1, 1'b1, 1'b0, 5'd16};
      "9": return {1'b1, 1'b1, 1'b0, 5'd3};
      "5": return {1'b1, 1'b1, 1'b0, 5'd1};
      "-": return {1'b1, 1'b1, 1'b0, 5'd24};
      " ": return {1'b1, 1'b0, 1'b1, 5'd4};
      7'h0d: return {1'b1, 1'b0, 1'b1, 5'd2};
      7'h0a: return {1'b1, 1'b0, 1'b1, 5'd8};
      default: return 8'd0;
    endcase
  endfunction

  task automatic enc_case(input logic [6:0] c, input int n, input int e0, input int e1,
                          input int exp_shift, input string tag);
    int got;
    int g0;
    int g1;
    got = 0; g0 = -1; g1 = -1;
    @(negedge clk);
    bd_ready = 1'b1; asc_valid = 1'b1; asc_data = c;
    @(negedge clk);
    asc_valid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      #1;
      if (bd_valid) begin
        if (got == 0) g0 = bd_data; else if (got == 1) g1 = bd_data;
        got++;
      end
      @(negedge clk);
    end
    check(got == n, {tag, " count"}, got, n);
    if (n > 0) check(g0 == e0, {tag, " first code"}, g0, e0);
    if (n > 1) check(g1 == e1, {tag, " second code"}, g1, e1);
    check(shift_state == exp_shift, {tag, " case"}, shift_state, exp_shift);
  endtask

  task automatic dec_case(input logic [4:0] c, input bit prints, input int ch,
                          input int exp_shift, input string tag);
    @(negedge clk);
    pr_ready = 1'b1; rx_valid = 1'b1; rx_data = c;
    @(negedge clk);
    rx_valid = 1'b0;
    #1;
    check(pr_valid == prints, {tag, " print valid"}, pr_valid, prints);
    if (prints) check(pr_data == ch, {tag, " char"}, pr_data, ch);
    check(shift_state == exp_shift, {tag, " case"}, shift_state, exp_shift);
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end

  initial begin
    logic [4:0] q[$];
    logic [6:0] pool[16];
    bit mshift;
    void'($urandom(32'd20250611));
    pool = '{"A", "a", "E", "e", "T", "t", "O", "3", "5", "9", "-", " ",
             7'h0d, 7'h0a, "B", "#"};

    repeat (3) @(negedge clk);
    #1;
    check(!bd_valid && !pr_valid && !shift_state && asc_ready, "R1 in reset",
          {bd_valid, pr_valid, shift_state, asc_ready}, 1);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); #1;
    check(!bd_valid && !pr_valid && !shift_state && asc_ready, "R1 after reset",
          {bd_valid, pr_valid, shift_state, asc_ready}, 1);

    enc_case("A", 1, 24, 0, 0, "R3 R4 A in letters");
    enc_case("3", 2, 27, 16, 1, "R2 R5 figures switch");
    enc_case("5", 1, 1, 0, 1, "R4 figure direct");
    enc_case("e", 2, 31, 16, 0, "R8 R2 lowercase letter switch");
    enc_case(" ", 1, 4, 0, 0, "R4 either-case space");
    enc_case("B", 0, 0, 0, 0, "R6 untranslatable");
    enc_case("#", 0, 0, 0, 0, "R6 untranslatable figure");
    enc_case("t", 1, 1, 0, 0, "R8 lowercase direct");

    // R7 and R12: key needing a switch while the line stalls
    @(negedge clk);
    bd_ready = 1'b0; asc_valid = 1'b1; asc_data = "9";
    @(negedge clk);
    asc_data = "A";
    #1;
    check(asc_ready == 1'b0, "R7 ready low while pending", asc_ready, 0);
    check(bd_valid && bd_data == 5'd27, "R5 figures code first", bd_data, 27);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check(bd_valid && bd_data == 5'd27, "R12 held under stall", bd_data, 27);
      check(asc_ready == 1'b0, "R7 still blocked", asc_ready, 0);
    end
    @(negedge clk);
    asc_valid = 1'b0; bd_ready = 1'b1;
    @(negedge clk); #1;
    check(bd_valid && bd_data == 5'd3, "R5 pending code next", bd_data, 3);
    @(negedge clk); #1;
    check(!bd_valid, "R5 nothing after pending", bd_valid, 0);
    check(shift_state == 1'b1, "R5 case figures", shift_state, 1);

    // receive side
    dec_case(5'd16, 1'b1, "3", 1, "R10 figures decode");
    dec_case(5'd31, 1'b0, 0, 0, "R9 letters code");
    dec_case(5'd16, 1'b1, "E", 0, "R10 letters decode");
    dec_case(5'd24, 1'b1, "A", 0, "R10 letter A");
    dec_case(5'd27, 1'b0, 0, 1, "R9 figures code");
    dec_case(5'd1, 1'b1, "5", 1, "R10 figure 5");
    dec_case(5'd4, 1'b1, " ", 1, "R10 space");
    dec_case(5'd5, 1'b1, 0, 1, "R10 no entry");

    // R12 on print path
    @(negedge clk);
    pr_ready = 1'b0; rx_valid = 1'b1; rx_data = 5'd3;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (3) begin
      @(negedge clk); #1;
      check(pr_valid && pr_data == "9", "R12 print held", pr_data, "9");
    end
    @(negedge clk); pr_ready = 1'b1;

    // R11: encoder asks letters, decoder sees figures, same cycle
    dec_case(5'd31, 1'b0, 0, 0, "R9 back to letters");
    dec_case(5'd27, 1'b0, 0, 1, "R9 to figures");
    @(negedge clk);
    bd_ready = 1'b1; pr_ready = 1'b1;
    asc_valid = 1'b1; asc_data = "T"; rx_valid = 1'b1; rx_data = 5'd27;
    @(negedge clk);
    asc_valid = 1'b0; rx_valid = 1'b0;
    #1;
    check(shift_state == 1'b1, "R11 decoder wins", shift_state, 1);
    check(bd_valid && bd_data == 5'd31, "R11 letters code sent", bd_data, 31);
    @(negedge clk); #1;
    check(bd_valid && bd_data == 5'd1, "R11 pending T", bd_data, 1);
    dec_case(5'd31, 1'b0, 0, 0, "R9 restore letters");

    // random keys with random backpressure
    mshift = 1'b0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      asc_valid = ($urandom % 2) == 0;
      asc_data  = pool[$urandom % 16];
      bd_ready  = ($urandom % 4) != 0;
      #1;
      if (bd_valid && bd_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R4 unexpected code", bd_data, -1);
        end else begin
          check(bd_data == q[0], "R4 R5 random stream", bd_data, q[0]);
          void'(q.pop_front());
        end
      end
      if (asc_valid && asc_ready) begin
        logic [7:0] e;
        e = model_entry(asc_data);
        if (e[7]) begin
          if (e[5] || e[6] == mshift) begin
            q.push_back(e[4:0]);
          end else begin
            q.push_back(e[6] ? 5'd27 : 5'd31);
            q.push_back(e[4:0]);
            mshift = e[6];
          end
        end
      end
    end
    @(negedge clk);
    asc_valid = 1'b0; bd_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      #1;
      if (bd_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R4 unexpected drain code", bd_data, -1);
        end else begin
          check(bd_data == q[0], "R5 drain stream", bd_data, q[0]);
          void'(q.pop_front());
        end
      end
      @(negedge clk);
    end
    check(q.size() == 0, "R5 all codes delivered", q.size(), 0);
    check(shift_state == mshift, "R5 random case track", shift_state, mshift);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end
endmodule